// File: doc/BRIEF.md
# Block Cipher Register Window

This block sits between a byte-wide host bus and a 128-bit block cipher core. A small address window holds a status byte, a control byte and a 16-byte buffer. The control byte can also be reached through a mirror address placed just past the buffer. The control byte selects what the buffer means. In key mode the buffer is the key store; in the two cipher modes it is the data state. Because the mirror sits one address past the last buffer byte, a host can write a whole block in one ascending burst and end that burst with the byte that starts processing.

When a start is accepted, the block freezes its key and state. It then offers them to the cipher core as one request. When the core answers, the result replaces the state bytes in the buffer and the done flag is set. Reads are combinational, so one bus cycle can return the previous result byte while it writes the next input byte at the same address. This lets the host pipeline blocks. The block clears everything and ignores the host while the sleep input is high, and it does the same while reset is asserted.

The core request is a valid/ready stream. Once `req_valid` is raised, it stays high with a stable payload until the core asserts `req_ready`, and it drops in the cycle after that handshake. The core response has no back-pressure: a `rsp_valid` pulse is taken while an operation is outstanding and is ignored at any other time.

Top module: `cipher_window`

## Requirements
- R1: Reset, and any clock edge with sleep high, clear the mode, the direction, the done flag, the key and the state to zero, and clear the pending request. `req_valid` is low in the cycle after such an edge.
- R2: While `sleep_i` is high, `bus_rdata` reads 0 and host writes have no effect.
- R3: The status byte is at 0x82, and its bit 0 is the done flag. The control byte is at both 0x83 and 0x94, and both addresses address one register. Control reads return {00, mode[1:0], dir, 000}, so bit 7 always reads 0.
- R4: The mode field is control bits 5:4: 00 = ECB, 01 = key, 10 = CBC, 11 = reserved. Address 0x84+i is key byte i when the mode is key, and state byte i otherwise. The key is kept while the mode changes.
- R5: A control write with bit 7 set starts an operation when the written mode is ECB or CBC and no operation is outstanding. `req_valid` rises in the next cycle. A request bit written with the key mode or the reserved mode does not start an operation.
- R6: `req_valid` stays high with `req_key` and `req_data` stable until `req_ready` is seen, and it is low in the cycle after the handshake. Here `req_key` byte i is key byte i at bits 8i+7:8i, and `req_data` is built the same way from the state.
- R7: `req_decrypt` is control bit 3 (0x08) when the mode is ECB, and is 0 in CBC. `req_cbc` is 1 exactly when the mode is CBC.
- R8: An accepted start clears done. A `rsp_valid` pulse while an operation is outstanding loads `rsp_data` into the state (byte i from bits 8i+7:8i) and sets done. A `rsp_valid` pulse with no operation outstanding changes nothing.
- R9: While an operation is outstanding, writes to the control byte and to the buffer are ignored.
- R10: In a cycle that both reads and writes a buffer address, `bus_rdata` returns the value from before the write.
- R11: Addresses outside 0x82..0x94 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep: clears state and blocks host access |
| bus_addr | input | 8 | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, combinational from bus_addr |
| req_valid | output | 1 | Cipher request valid |
| req_ready | input | 1 | Cipher core accepts request |
| req_key | output | 128 | Key bytes offered to the core |
| req_data | output | 128 | State bytes offered to the core |
| req_decrypt | output | 1 | Request is a decryption |
| req_cbc | output | 1 | Request uses chained mode |
| rsp_valid | input | 1 | Cipher core result pulse |
| rsp_data | input | 128 | Cipher core result bytes |

## Verification
The assertions check the following on every cycle: the read bus is quiet during sleep and for unmapped addresses, the request stays held and stable under back-pressure, a mirror write with the request bit starts an operation, CBC requests never claim decryption, and done behaves correctly around start and completion. Some behaviour can only be shown by the bench's scenarios, where its model follows every byte of key and state. This covers which store the buffer shows in each mode, and that the key is kept across mode changes. It also covers writes being ignored while busy or asleep, and the read-before-write result of a combined cycle. Finally it covers that a stray response leaves the buffer unchanged.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [1:0] {
    MODE_ECB  = 2'd0,
    MODE_KEY  = 2'd1,
    MODE_CBC  = 2'd2,
    MODE_RSVD = 2'd3
  } cw_mode_e;

  localparam int unsigned BLK_BYTES   = 16;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned STATUS_ADDR = 'h82;
  localparam int unsigned CTRL_ADDR   = 'h83;
  localparam int unsigned BUF_BASE    = 'h84;

  function automatic logic mode_runs(input cw_mode_e m);
    return (m == MODE_ECB) || (m == MODE_CBC);
  endfunction
endpackage

// File: rtl/cw_decode.sv
module cw_decode #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NBYTES      = 16,
  parameter int unsigned STATUS_ADDR = 'h82,
  parameter int unsigned CTRL_ADDR   = 'h83,
  parameter int unsigned BUF_BASE    = 'h84,
  localparam int unsigned IDX_W      = $clog2(NBYTES),
  localparam int unsigned MIRROR     = BUF_BASE + NBYTES
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_status,
  output logic              hit_ctrl,
  output logic              hit_buf,
  output logic [IDX_W-1:0]  idx
);
  assign hit_status = (addr == ADDR_W'(STATUS_ADDR));
  assign hit_ctrl   = (addr == ADDR_W'(CTRL_ADDR)) || (addr == ADDR_W'(MIRROR));

  always_comb begin
    hit_buf = 1'b0;
    idx     = '0;
    for (int i = 0; i < int'(NBYTES); i++) begin
      if (addr == ADDR_W'(BUF_BASE + i)) begin
        hit_buf = 1'b1;
        idx     = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/cw_ctrl.sv
module cw_ctrl
  import cw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sleep_i,
  input  logic     ctrl_we,
  input  logic     wr_req,
  input  cw_mode_e wr_mode,
  input  logic     wr_dir,
  input  logic     req_ready,
  input  logic     rsp_valid,
  output cw_mode_e mode,
  output logic     dir,
  output logic     busy,
  output logic     done,
  output logic     req_valid,
  output logic     complete
);
  logic accept;

  // a start needs an idle engine and a mode that runs the cipher
  assign accept   = ctrl_we && !busy && wr_req && mode_runs(wr_mode);
  assign complete = busy && rsp_valid && !sleep_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_ECB;
      dir       <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      req_valid <= 1'b0;
    end else if (sleep_i) begin
      mode      <= MODE_ECB;
      dir       <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      req_valid <= 1'b0;
    end else begin
      if (complete) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        req_valid <= 1'b0;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end
      if (ctrl_we && !busy) begin
        mode <= wr_mode;
        dir  <= wr_dir;
      end
      if (accept) begin
        busy      <= 1'b1;
        done      <= 1'b0;
        req_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cw_store.sv
module cw_store #(
  parameter int unsigned NBYTES = 16,
  localparam int unsigned IDX_W = $clog2(NBYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_i,
  input  logic                buf_we,
  input  logic                sel_key,
  input  logic [IDX_W-1:0]    idx,
  input  logic [7:0]          wdata,
  input  logic                load,
  input  logic [NBYTES*8-1:0] load_data,
  output logic [NBYTES*8-1:0] key_vec,
  output logic [NBYTES*8-1:0] state_vec,
  output logic [7:0]          rd_byte
);
  logic [NBYTES-1:0][7:0] key_q;
  logic [NBYTES-1:0][7:0] state_q;
  logic [NBYTES-1:0][7:0] load_b;

  assign load_b = load_data;

  for (genvar i = 0; i < int'(NBYTES); i++) begin : g_byte
    logic hit;
    assign hit = buf_we && (idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        key_q[i] <= '0;
      end else if (sleep_i) begin
        key_q[i] <= '0;
      end else if (hit && sel_key) begin
        key_q[i] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        state_q[i] <= '0;
      end else if (sleep_i) begin
        state_q[i] <= '0;
      end else if (load) begin
        state_q[i] <= load_b[i];
      end else if (hit && !sel_key) begin
        state_q[i] <= wdata;
      end
    end
  end

  assign key_vec   = key_q;
  assign state_vec = state_q;
  assign rd_byte   = sel_key ? key_q[idx] : state_q[idx];
endmodule

// File: rtl/cipher_window.sv
module cipher_window
  import cw_pkg::*;
#(
  parameter int unsigned ADDR_W      = cw_pkg::ADDR_W,
  parameter int unsigned NBYTES      = cw_pkg::BLK_BYTES,
  parameter int unsigned STATUS_ADDR = cw_pkg::STATUS_ADDR,
  parameter int unsigned CTRL_ADDR   = cw_pkg::CTRL_ADDR,
  parameter int unsigned BUF_BASE    = cw_pkg::BUF_BASE,
  localparam int unsigned BLK_W      = NBYTES * 8,
  localparam int unsigned IDX_W      = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BLK_W-1:0]  req_key,
  output logic [BLK_W-1:0]  req_data,
  output logic              req_decrypt,
  output logic              req_cbc,
  input  logic              rsp_valid,
  input  logic [BLK_W-1:0]  rsp_data
);
  logic             hit_status, hit_ctrl, hit_buf;
  logic [IDX_W-1:0] idx;
  logic             host_we;
  cw_mode_e         mode;
  logic             dir, busy, done, complete;
  logic [7:0]       buf_byte;

  assign host_we = bus_wr && !sleep_i;

  cw_decode #(
    .ADDR_W(ADDR_W), .NBYTES(NBYTES), .STATUS_ADDR(STATUS_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .BUF_BASE(BUF_BASE)
  ) u_dec (
    .addr(bus_addr), .hit_status(hit_status), .hit_ctrl(hit_ctrl),
    .hit_buf(hit_buf), .idx(idx)
  );

  cw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
    .ctrl_we(host_we && hit_ctrl), .wr_req(bus_wdata[7]),
    .wr_mode(cw_mode_e'(bus_wdata[5:4])), .wr_dir(bus_wdata[3]),
    .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mode(mode), .dir(dir), .busy(busy), .done(done),
    .req_valid(req_valid), .complete(complete)
  );

  cw_store #(.NBYTES(NBYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
    .buf_we(host_we && hit_buf && !busy), .sel_key(mode == MODE_KEY),
    .idx(idx), .wdata(bus_wdata), .load(complete), .load_data(rsp_data),
    .key_vec(req_key), .state_vec(req_data), .rd_byte(buf_byte)
  );

  assign req_decrypt = (mode == MODE_ECB) && dir;
  assign req_cbc     = (mode == MODE_CBC);

  always_comb begin
    bus_rdata = '0;
    if (!sleep_i) begin
      if (hit_status)    bus_rdata = {7'b0, done};
      else if (hit_ctrl) bus_rdata = {2'b00, mode, dir, 3'b000};
      else if (hit_buf)  bus_rdata = buf_byte;
    end
  end
endmodule

// File: rtl/cw_checker.sv
module cw_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         sleep_i,
  input logic [7:0]   bus_addr,
  input logic         bus_wr,
  input logic [7:0]   bus_wdata,
  input logic [7:0]   bus_rdata,
  input logic         req_valid,
  input logic         req_ready,
  input logic [127:0] req_key,
  input logic [127:0] req_data,
  input logic         req_decrypt,
  input logic         req_cbc,
  input logic         rsp_valid,
  input logic         busy,
  input logic         done
);
  AST_SLEEP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> bus_rdata == 8'h00); // R2

  AST_SLEEP_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !req_valid); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < 8'h82 || bus_addr > 8'h94) |-> bus_rdata == 8'h00); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n || sleep_i)
    (req_valid && !req_ready && !rsp_valid) |=>
      (req_valid && $stable(req_key) && $stable(req_data))); // R6

  AST_MIRROR_START: assert property (@(posedge clk) disable iff (!rst_n || sleep_i)
    (bus_wr && bus_addr == 8'h94 && bus_wdata[7] && bus_wdata[5:4] == 2'b00 && !busy)
      |=> req_valid); // R5

  AST_CBC_NO_DECRYPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_cbc |-> !req_decrypt); // R7

  AST_DONE_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n || sleep_i)
    (busy && rsp_valid) |=> done); // R8

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !done); // R8
endmodule

bind cipher_window cw_checker u_chk (.*);

// File: tb/tb_cipher_window.sv
`timescale 1ns/1ps
module tb_cipher_window;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_i = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic req_valid, req_decrypt, req_cbc;
  logic req_ready = 1'b1;
  logic [127:0] req_key, req_data;
  logic rsp_valid = 1'b0;
  logic [127:0] rsp_data = '0;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cipher_window dut (.*);

  // behavioural reference model
  logic [7:0] mk [16];
  logic [7:0] ms [16];
  int m_mode = 0;
  bit m_dir = 0, m_busy = 0, m_done = 0, m_valid = 0;

  task automatic m_clear();
    foreach (mk[i]) begin mk[i] = 0; ms[i] = 0; end
    m_mode = 0; m_dir = 0; m_busy = 0; m_done = 0; m_valid = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || sleep_i) m_clear();
    else begin
      bit was_busy;
      int a;
      was_busy = m_busy;
      a = int'(bus_addr);
      if (was_busy && rsp_valid) begin
        for (int i = 0; i < 16; i++) ms[i] = rsp_data[8*i +: 8];
        m_done = 1; m_busy = 0; m_valid = 0;
      end else if (m_valid && req_ready) m_valid = 0;
      if (bus_wr && !was_busy) begin
        if (a == 'h83 || a == 'h94) begin
          int nm;
          nm = int'(bus_wdata[5:4]);
          if (bus_wdata[7] && (nm == 0 || nm == 2)) begin
            m_valid = 1; m_busy = 1; m_done = 0;
          end
          m_mode = nm; m_dir = bus_wdata[3];
        end else if (a >= 'h84 && a <= 'h93) begin
          if (m_mode == 1) mk[a - 'h84] = bus_wdata;
          else ms[a - 'h84] = bus_wdata;
        end
      end
    end
  end

  function automatic logic [7:0] m_rdata();
    int a;
    a = int'(bus_addr);
    if (sleep_i) return 0;
    if (a == 'h82) return {7'b0, m_done};
    if (a == 'h83 || a == 'h94) return {2'b00, 2'(m_mode), m_dir, 3'b000};
    if (a >= 'h84 && a <= 'h93) return (m_mode == 1) ? mk[a - 'h84] : ms[a - 'h84];
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [127:0] ek, es;
      for (int i = 0; i < 16; i++) begin ek[8*i +: 8] = mk[i]; es[8*i +: 8] = ms[i]; end
      chk({cur_req, " model rdata"}, 128'(bus_rdata), 128'(m_rdata()));
      chk({cur_req, " model req_valid"}, 128'(req_valid), 128'(m_valid));
      chk({cur_req, " model req_decrypt"}, 128'(req_decrypt), 128'(m_mode == 0 && m_dir));
      chk({cur_req, " model req_cbc"}, 128'(req_cbc), 128'(m_mode == 2));
      chk({cur_req, " model req_key"}, req_key, ek);
      chk({cur_req, " model req_data"}, req_data, es);
    end
  end

  task automatic cyc(input logic [7:0] a, input logic w, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = w; bus_wdata = d; rsp_valid = 1'b0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [7:0] d); cyc(a, 1'b1, d); endtask
  task automatic idle(); cyc(8'h00, 1'b0, 8'h00); @(negedge clk); endtask
  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    cyc(a, 1'b0, 8'h00);
    @(negedge clk);
    chk(tag, 128'(bus_rdata), 128'(exp));
  endtask
  task automatic rsp(input logic [127:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 8'h00; rsp_valid = 1'b1; rsp_data = d;
  endtask

  localparam logic [127:0] RES = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] kv;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    rd_chk(8'h82, 8'h00, "R1 status after reset");
    rd_chk(8'h83, 8'h00, "R1 ctrl after reset");
    rd_chk(8'h90, 8'h00, "R1 buffer after reset");
    chk("R1 req_valid after reset", 128'(req_valid), 128'(0));

    cur_req = "R4";
    wr(8'h83, 8'h10);
    for (int i = 0; i < 16; i++) wr(8'(8'h84 + i), 8'(8'hA0 + i));
    rd_chk(8'h94, 8'h10, "R3 mirror reads ctrl");
    rd_chk(8'h84, 8'hA0, "R4 key byte 0");
    rd_chk(8'h93, 8'hAF, "R4 key byte 15");
    wr(8'h83, 8'h00);
    rd_chk(8'h84, 8'h00, "R4 state view empty");
    for (int i = 0; i < 16; i++) wr(8'(8'h84 + i), 8'(8'h10 + i));

    cur_req = "R6";
    req_ready = 1'b0;
    wr(8'h94, 8'h80);
    rd_chk(8'h82, 8'h00, "R8 done low after start");
    chk("R5 req_valid after mirror start", 128'(req_valid), 128'(1));
    for (int i = 0; i < 16; i++) kv[8*i +: 8] = 8'(8'hA0 + i);
    chk("R6 req_key bytes", req_key, kv);
    rd_chk(8'h94, 8'h00, "R6 request bit self-clears");
    cur_req = "R9";
    wr(8'h84, 8'hEE);
    wr(8'h83, 8'h10);
    rd_chk(8'h84, 8'h10, "R9 buffer write ignored while busy");
    rd_chk(8'h83, 8'h00, "R9 ctrl write ignored while busy");
    chk("R6 req_valid held", 128'(req_valid), 128'(1));
    cur_req = "R6";
    req_ready = 1'b1;
    idle();
    chk("R6 req_valid drops after handshake", 128'(req_valid), 128'(0));
    cur_req = "R8";
    rsp(RES);
    rd_chk(8'h82, 8'h01, "R8 done after response");
    rd_chk(8'h84, 8'h0F, "R8 result byte 0");
    rd_chk(8'h93, 8'hF0, "R8 result byte 15");

    cur_req = "R10";
    cyc(8'h84, 1'b1, 8'h33);
    @(negedge clk);
    chk("R10 read before write", 128'(bus_rdata), 128'(8'h0F));
    rd_chk(8'h84, 8'h33, "R10 new byte stored");
    wr(8'h83, 8'h10);
    rd_chk(8'h85, 8'hA1, "R4 key kept across modes");

    cur_req = "R7";
    wr(8'h94, 8'h88);
    idle();
    chk("R7 ECB decrypt flag", 128'(req_decrypt), 128'(1));
    rsp(RES);
    wr(8'h94, 8'hA8);
    idle();
    chk("R7 CBC forces encrypt", 128'(req_decrypt), 128'(0));
    chk("R7 CBC flag", 128'(req_cbc), 128'(1));
    rd_chk(8'h83, 8'h28, "R3 ctrl fields read back");
    rsp(RES);

    cur_req = "R5";
    wr(8'h94, 8'h90);
    idle();
    chk("R5 key mode request ignored", 128'(req_valid), 128'(0));
    rd_chk(8'h82, 8'h01, "R5 done kept without start");
    wr(8'h94, 8'hB0);
    idle();
    chk("R5 reserved mode request ignored", 128'(req_valid), 128'(0));
    rd_chk(8'h83, 8'h30, "R5 reserved mode stored");

    cur_req = "R8";
    wr(8'h83, 8'h00);
    rsp(128'h0);
    rd_chk(8'h84, 8'h0F, "R8 stray response ignored");

    cur_req = "R11";
    wr(8'h95, 8'h55);
    wr(8'h81, 8'h55);
    rd_chk(8'h95, 8'h00, "R11 above window reads 0");
    rd_chk(8'h81, 8'h00, "R11 below window reads 0");
    rd_chk(8'h84, 8'h0F, "R11 buffer untouched");
    rd_chk(8'h83, 8'h00, "R11 ctrl untouched");

    cur_req = "R2";
    wr(8'h94, 8'h80);
    sleep_i = 1'b1;
    rd_chk(8'h82, 8'h00, "R2 sleep reads 0");
    chk("R1 sleep drops request", 128'(req_valid), 128'(0));
    wr(8'h83, 8'h10);
    wr(8'h84, 8'h77);
    idle();
    sleep_i = 1'b0;
    cur_req = "R1";
    rd_chk(8'h83, 8'h00, "R1 ctrl cleared by sleep");
    rd_chk(8'h84, 8'h00, "R1 state cleared by sleep");
    rd_chk(8'h82, 8'h00, "R1 done cleared by sleep");
    wr(8'h83, 8'h10);
    rd_chk(8'h84, 8'h00, "R1 key cleared by sleep");
    idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule